// File: doc/BRIEF.md
# Configurable AND-Inverter Reduction Tree

This block evaluates one partition of an and-inverter graph. The graph is folded into a halving tree whose leaves are 8192 Boolean signals, kept as 256 words of 32 bits in a state memory. At each level, pairs of words are combined bit by bit. Every bit position has its own gate, configured by three masks: one inverts input A, one inverts input B, and one forces the B term true so that the output is a copy of the (possibly inverted) A input. With these masks, each bit can be mapped to an arbitrary AND-inverter node or to a plain copy of a signal.

Before a run, software-side logic loads the leaf words, the gate masks and the capture hooks through two write ports. A start pulse then walks the thirteen levels in order, one level per clock. The first eight levels work on whole words. The last five levels fold the bits inside word 1. Up to eight hooks each copy one state word, as it stands after a chosen level, into a write-out slot. This lets intermediate nodes be read out as well as the root. A one-cycle done pulse marks the point at which the write-out slots are valid.

Top module: `aig_tree`

## Requirements
- R1: After reset, done_o is low, every write-out slot reads zero, every gate mask is zero (plain AND), and every hook has level field 15, so it never captures.
- R2: Configuration address map (cfg_addr_i, 9 bits). Addresses 0x000–0x0FF hold the mask triple for word position addr; the level is implied by the position. Addresses 0x100–0x104 hold the mask triple for bit levels 8–12. Address 0x180+s sets hook s from cfg_xa_i[11:0], with bits [11:8] the level and bits [7:0] the word index. Leaf writes put leaf_data_i into state word leaf_addr_i.
- R3: Each gate bit computes (a XOR xa) AND ((b XOR xb) OR ob). With ob set and xa clear, the output copies a. With xa and xb set and ob clear, the output is NOR(a, b).
- R4: Level 0 updates positions 128–255. Position i takes a from word i−128 and b from word i.
- R5: Levels 1–7 use widths w = 64, 32, 16, 8, 4, 2, 1. Positions i with w ≤ i < 2w take a from word i+w and b from word i+2w. Each level sees every result of the level before it.
- R6: Levels 8–12 act on word 1 with shift amounts 16, 8, 4, 2, 1 and result masks 0xFFFF0000, 0x0000FF00, 0x000000F0, 0x0000000C, 0x00000002. Level 8 takes a = word<<16 and b = word, and replaces the word with its masked result. Each later level with shift h takes a = word>>h and b = word>>2h, and ORs its masked result into the word. The tree root is bit 1 of word 1.
- R7: A hook whose level field L is in 0–12 copies its indexed word, as it stands after level L, into its slot. A level field of 13–15 never captures, and that slot keeps its earlier value.
- R8: One level is evaluated per clock. done_o is a one-cycle pulse, high during the 15th cycle after the cycle in which start_i was sampled. A start_i that arrives while a run is in progress is ignored.
- R9: Leaf writes and configuration writes made while a run is in progress have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| leaf_we_i | input | 1 | Leaf word write strobe |
| leaf_addr_i | input | 8 | Leaf word index |
| leaf_data_i | input | 32 | Leaf word data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 9 | Configuration address (see R2) |
| cfg_xa_i | input | 32 | A-inversion mask, or hook value in bits [11:0] |
| cfg_xb_i | input | 32 | B-inversion mask |
| cfg_ob_i | input | 32 | Pass-through mask |
| start_i | input | 1 | Start a run |
| done_o | output | 1 | One-cycle pulse: write-out slots valid |
| wo_o | output | NUM_WO*32 | Write-out slots, slot s at bits [32s+31:32s] |

## Verification
The tree is driven with several distinct patterns, each of which separates a different class of fault:
- All-ones leaves with reset masks test the plain-AND default and the exact bit-level mask pattern at the root. A single cleared leaf bit then tests that every leaf reaches the root.
- All-set pass-through masks and all-set inversion masks check the copy and NOR readings of the formula against values taken directly from the leaves. A mistake in operand routing shows up here instead of cancelling out.
- Random masks and leaves, with hooks spread over all thirteen levels, are compared against a level-by-level model. This finds wrong sources, wrong level order and wrong capture timing.
- Separate runs check the done latency, the behaviour of hooks that never capture, and writes or restarts issued in the middle of a run.

// File: rtl/aig_tree_pkg.sv
package aig_tree_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 256;
  localparam int unsigned ADDR_W    = $clog2(NUM_WORDS);
  localparam int unsigned NUM_WLVL  = ADDR_W;          // word levels 0..7
  localparam int unsigned NUM_BLVL  = $clog2(WORD_W);  // bit levels 8..12
  localparam int unsigned NUM_LVL   = NUM_WLVL + NUM_BLVL;
  localparam int unsigned LVL_W     = 4;
  localparam int unsigned CFG_AW    = ADDR_W + 1;
  localparam int unsigned HOOK_W    = LVL_W + ADDR_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t xa;
    word_t xb;
    word_t ob;
  } gcfg_t;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic [ADDR_W-1:0] idx;
  } hook_t;

  function automatic word_t gate_f(word_t a, word_t b, gcfg_t c);
    return (a ^ c.xa) & ((b ^ c.xb) | c.ob);
  endfunction

  // level at which a word position is written; 15 = never
  function automatic int pos_level(int i);
    int lg;
    lg = 0;
    for (int j = 0; j < int'(ADDR_W); j++)
      if (((i >> j) & 1) != 0) lg = j;
    if (i == 0) return 15;
    return int'(NUM_WLVL) - 1 - lg;
  endfunction

  function automatic word_t blvl_mask(int j);
    word_t m;
    m = '0;
    for (int k = 0; k < int'(WORD_W) >> j; k++)
      if (k >= (int'(WORD_W) >> (j + 1))) m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/aig_tree_ctrl.sv
module aig_tree_ctrl
  import aig_tree_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             run_o,
  output logic [LVL_W-1:0] step_o,
  output logic             cap_en_o,
  output logic [LVL_W-1:0] cap_lvl_o,
  output logic             done_o
);
  typedef enum logic [1:0] {CT_IDLE, CT_RUN, CT_CAP} ct_e;

  localparam logic [LVL_W-1:0] LAST = LVL_W'(NUM_LVL - 1);

  ct_e              st_q;
  logic [LVL_W-1:0] step_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CT_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        CT_IDLE: if (start_i) begin
          st_q   <= CT_RUN;
          step_q <= '0;
        end
        CT_RUN: begin
          if (step_q == LAST) st_q <= CT_CAP;
          else                step_q <= step_q + 1'b1;
        end
        CT_CAP: begin
          st_q   <= CT_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end

  assign run_o     = (st_q == CT_RUN);
  assign busy_o    = (st_q != CT_IDLE);
  assign step_o    = step_q;
  // hooks of level L sample the state one cycle after L is written
  assign cap_en_o  = (run_o && step_q != '0) || (st_q == CT_CAP);
  assign cap_lvl_o = (st_q == CT_CAP) ? LAST : step_q - 1'b1;
  assign done_o    = done_q;
endmodule

// File: rtl/aig_tree_cfg.sv
module aig_tree_cfg
  import aig_tree_pkg::*;
#(
  parameter int unsigned NUM_WO = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  word_t             xa_i,
  input  word_t             xb_i,
  input  word_t             ob_i,
  output gcfg_t             pos_cfg_o [NUM_WORDS],
  output gcfg_t             bit_cfg_o [NUM_BLVL],
  output hook_t             hook_o    [NUM_WO]
);
  localparam int unsigned SLOT_W = (NUM_WO > 1) ? $clog2(NUM_WO) : 1;

  gcfg_t pos_q [NUM_WORDS];
  gcfg_t bit_q [NUM_BLVL];
  hook_t hook_q [NUM_WO];
  gcfg_t wdata;

  assign wdata = '{xa: xa_i, xb: xb_i, ob: ob_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_WORDS); i++) pos_q[i] <= '0;
      for (int i = 0; i < int'(NUM_BLVL); i++)  bit_q[i] <= '0;
      for (int i = 0; i < int'(NUM_WO); i++)    hook_q[i] <= '{lvl: '1, idx: '0};
    end else if (we_i) begin
      if (!addr_i[CFG_AW-1]) begin
        pos_q[addr_i[ADDR_W-1:0]] <= wdata;
      end else if (!addr_i[CFG_AW-2]) begin
        for (int i = 0; i < int'(NUM_BLVL); i++)
          if (int'(addr_i[CFG_AW-3:0]) == i) bit_q[i] <= wdata;
      end else begin
        for (int i = 0; i < int'(NUM_WO); i++)
          if (int'(addr_i[CFG_AW-3:0]) == i) hook_q[i] <= hook_t'(xa_i[HOOK_W-1:0]);
      end
    end
  end

  assign pos_cfg_o = pos_q;
  assign bit_cfg_o = bit_q;
  assign hook_o    = hook_q;

  logic unused_slot;
  assign unused_slot = ^SLOT_W;
endmodule

// File: rtl/aig_tree_wgates.sv
module aig_tree_wgates
  import aig_tree_pkg::*;
(
  input  word_t state_i [NUM_WORDS],
  input  gcfg_t cfg_i   [NUM_WORDS],
  output word_t res_o   [NUM_WORDS]
);
  localparam int HALF = int'(NUM_WORDS) / 2;

  assign res_o[0] = '0;

  for (genvar i = 1; i < int'(NUM_WORDS); i++) begin : g_pos
    localparam int LV  = pos_level(i);
    localparam int W   = 1 << (int'(NUM_WLVL) - 1 - LV);
    localparam int SRC_A = (LV == 0) ? i - HALF : i + W;
    localparam int SRC_B = (LV == 0) ? i        : i + 2 * W;
    assign res_o[i] = gate_f(state_i[SRC_A], state_i[SRC_B], cfg_i[i]);
  end
endmodule

// File: rtl/aig_tree_bgate.sv
module aig_tree_bgate
  import aig_tree_pkg::*;
(
  input  word_t                     v_i,
  input  logic [$clog2(NUM_BLVL):0] sel_i,
  input  gcfg_t                     cfg_i,
  output word_t                     res_o
);
  word_t a, b, m;
  int    sh;

  always_comb begin
    sh = int'(WORD_W) >> (int'(sel_i) + 1);
    m  = blvl_mask(int'(sel_i));
    if (sel_i == '0) begin
      a = v_i << sh;
      b = v_i;
      res_o = gate_f(a, b, cfg_i) & m;
    end else begin
      a = v_i >> sh;
      b = v_i >> (2 * sh);
      res_o = v_i | (gate_f(a, b, cfg_i) & m);
    end
  end
endmodule

// File: rtl/aig_tree_wo.sv
module aig_tree_wo
  import aig_tree_pkg::*;
#(
  parameter int unsigned NUM_WO = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_en_i,
  input  logic [LVL_W-1:0]         cap_lvl_i,
  input  hook_t                    hook_i  [NUM_WO],
  input  word_t                    state_i [NUM_WORDS],
  output logic [NUM_WO*WORD_W-1:0] wo_o
);
  word_t wo_q [NUM_WO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(NUM_WO); s++) wo_q[s] <= '0;
    end else if (cap_en_i) begin
      for (int s = 0; s < int'(NUM_WO); s++)
        if (hook_i[s].lvl == cap_lvl_i) wo_q[s] <= state_i[hook_i[s].idx];
    end
  end

  for (genvar s = 0; s < int'(NUM_WO); s++) begin : g_out
    assign wo_o[s*WORD_W +: WORD_W] = wo_q[s];
  end
endmodule

// File: rtl/aig_tree.sv
module aig_tree
  import aig_tree_pkg::*;
#(
  parameter int unsigned NUM_WO = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     leaf_we_i,
  input  logic [7:0]               leaf_addr_i,
  input  logic [31:0]              leaf_data_i,
  input  logic                     cfg_we_i,
  input  logic [8:0]               cfg_addr_i,
  input  logic [31:0]              cfg_xa_i,
  input  logic [31:0]              cfg_xb_i,
  input  logic [31:0]              cfg_ob_i,
  input  logic                     start_i,
  output logic                     done_o,
  output logic [NUM_WO*32-1:0]     wo_o
);
  localparam int unsigned SEL_W = $clog2(NUM_BLVL) + 1;

  logic             busy, run, cap_en;
  logic [LVL_W-1:0] step, cap_lvl;
  logic [SEL_W-1:0] bsel;
  word_t            state_q [NUM_WORDS];
  word_t            wres    [NUM_WORDS];
  word_t            bres;
  gcfg_t            pos_cfg [NUM_WORDS];
  gcfg_t            bit_cfg [NUM_BLVL];
  gcfg_t            bcfg;
  hook_t            hooks   [NUM_WO];
  logic             leaf_wr, cfg_wr, bit_step;

  assign leaf_wr  = leaf_we_i && !busy;
  assign cfg_wr   = cfg_we_i  && !busy;
  assign bit_step = run && (int'(step) >= int'(NUM_WLVL));
  assign bsel     = bit_step ? SEL_W'(step - LVL_W'(NUM_WLVL)) : '0;
  assign bcfg     = bit_cfg[bsel];

  aig_tree_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .busy_o(busy), .run_o(run), .step_o(step),
    .cap_en_o(cap_en), .cap_lvl_o(cap_lvl), .done_o
  );

  aig_tree_cfg #(.NUM_WO(NUM_WO)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_wr), .addr_i(cfg_addr_i),
    .xa_i(cfg_xa_i), .xb_i(cfg_xb_i), .ob_i(cfg_ob_i),
    .pos_cfg_o(pos_cfg), .bit_cfg_o(bit_cfg), .hook_o(hooks)
  );

  aig_tree_wgates u_wg (.state_i(state_q), .cfg_i(pos_cfg), .res_o(wres));

  aig_tree_bgate u_bg (.v_i(state_q[1]), .sel_i(bsel), .cfg_i(bcfg), .res_o(bres));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_WORDS); i++) state_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(NUM_WORDS); i++) begin
        if (leaf_wr && int'(leaf_addr_i) == i)
          state_q[i] <= leaf_data_i;
        else if (run && int'(step) == pos_level(i))
          state_q[i] <= wres[i];
        else if (i == 1 && bit_step)
          state_q[i] <= bres;
      end
    end
  end

  aig_tree_wo #(.NUM_WO(NUM_WO)) u_wo (
    .clk_i, .rst_ni, .cap_en_i(cap_en), .cap_lvl_i(cap_lvl),
    .hook_i(hooks), .state_i(state_q), .wo_o
  );
endmodule

// File: rtl/aig_tree_chk.sv
module aig_tree_chk #(
  parameter int unsigned NUM_WO = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 done_i,
  input logic                 busy_i,
  input logic [3:0]           step_i,
  input logic [31:0]          word0_i,
  input logic [NUM_WO*32-1:0] wo_i
);
  logic [4:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lat_q <= '0;
    else if (start_i && !busy_i)   lat_q <= 5'd1;
    else if (lat_q != '0 && lat_q < 5'd15) lat_q <= lat_q + 5'd1;
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r8_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> lat_q == 5'd15);

  a_r8_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  a_r8_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> step_i <= 4'd12);

  a_r9_word0_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(word0_i));

  a_r7_wo_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(wo_i));
endmodule

bind aig_tree aig_tree_chk #(.NUM_WO(NUM_WO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_i(done_o),
  .busy_i(busy), .step_i(step), .word0_i(state_q[0]), .wo_i(wo_o)
);

// File: tb/aig_tree_bench.sv
module aig_tree_bench;
  localparam int NWO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic leaf_we = 1'b0;
  logic [7:0] leaf_addr = '0;
  logic [31:0] leaf_data = '0;
  logic cfg_we = 1'b0;
  logic [8:0] cfg_addr = '0;
  logic [31:0] cfg_xa = '0, cfg_xb = '0, cfg_ob = '0;
  logic start = 1'b0;
  logic done;
  logic [NWO*32-1:0] wo;

  always #5 clk = ~clk;

  aig_tree #(.NUM_WO(NWO)) u_aig_tree (
    .clk_i(clk), .rst_ni(rst_n),
    .leaf_we_i(leaf_we), .leaf_addr_i(leaf_addr), .leaf_data_i(leaf_data),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_xa_i(cfg_xa), .cfg_xb_i(cfg_xb), .cfg_ob_i(cfg_ob),
    .start_i(start), .done_o(done), .wo_o(wo)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] m_leaf [256];
  logic [31:0] m_xa [256], m_xb [256], m_ob [256];
  logic [31:0] b_xa [5], b_xb [5], b_ob [5];
  logic [11:0] m_hook [NWO];
  logic [31:0] m_wo [NWO];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mg(logic [31:0] a, b, xa, xb, ob);
    return (a ^ xa) & ((b ^ xb) | ob);
  endfunction

  function automatic logic [31:0] slot(int s);
    return wo[s*32 +: 32];
  endfunction

  task automatic model_run();
    logic [31:0] st [256];
    logic [31:0] msk [5];
    msk[0] = 32'hFFFF0000; msk[1] = 32'h0000FF00; msk[2] = 32'h000000F0;
    msk[3] = 32'h0000000C; msk[4] = 32'h00000002;
    for (int i = 0; i < 256; i++) st[i] = m_leaf[i];
    for (int lv = 0; lv < 13; lv++) begin
      if (lv == 0) begin
        for (int i = 128; i < 256; i++)
          st[i] = mg(st[i-128], st[i], m_xa[i], m_xb[i], m_ob[i]);
      end else if (lv < 8) begin
        int w = 1 << (7 - lv);
        for (int i = w; i < 2*w; i++)
          st[i] = mg(st[i+w], st[i+2*w], m_xa[i], m_xb[i], m_ob[i]);
      end else begin
        int j = lv - 8;
        int h = 16 >> j;
        logic [31:0] v = st[1];
        if (j == 0) st[1] = mg(v << 16, v, b_xa[0], b_xb[0], b_ob[0]) & msk[0];
        else st[1] = v | (mg(v >> h, v >> (2*h), b_xa[j], b_xb[j], b_ob[j]) & msk[j]);
      end
      for (int s = 0; s < NWO; s++)
        if (int'(m_hook[s][11:8]) == lv) m_wo[s] = st[m_hook[s][7:0]];
    end
  endtask

  task automatic cfg_write(logic [8:0] a, logic [31:0] xa, xb, ob);
    cfg_we = 1'b1; cfg_addr = a; cfg_xa = xa; cfg_xb = xb; cfg_ob = ob;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic leaf_write(logic [7:0] a, logic [31:0] d);
    leaf_we = 1'b1; leaf_addr = a; leaf_data = d;
    @(negedge clk);
    leaf_we = 1'b0;
  endtask

  task automatic load_leaves_hooks();
    for (int i = 0; i < 256; i++) leaf_write(8'(i), m_leaf[i]);
    for (int s = 0; s < NWO; s++) cfg_write(9'h180 + 9'(s), {20'd0, m_hook[s]}, '0, '0);
  endtask

  task automatic load_all();
    for (int i = 0; i < 256; i++) cfg_write(9'(i), m_xa[i], m_xb[i], m_ob[i]);
    for (int j = 0; j < 5; j++) cfg_write(9'h100 + 9'(j), b_xa[j], b_xb[j], b_ob[j]);
    load_leaves_hooks();
  endtask

  // poke: hold writes to word 200 and word-1 masks, and retrigger start, mid-run
  task automatic run_dut(output int lat, input bit poke);
    lat = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (poke) begin
      leaf_we = 1'b1; leaf_addr = 8'd200; leaf_data = ~m_wo[2];
      cfg_we = 1'b1; cfg_addr = 9'd1; cfg_xa = 32'h5A5A_A5A5; cfg_xb = 32'h0F0F_F0F0; cfg_ob = 32'h0;
    end
    while (!done && lat < 40) begin
      if (poke) start = (lat == 3);
      @(negedge clk);
      lat++;
    end
    start = 1'b0; leaf_we = 1'b0; cfg_we = 1'b0;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: done never rose, waited %0d cycles expected 15", lat);
    end
  endtask

  task automatic compare_slots(string req);
    for (int s = 0; s < NWO; s++) check(req, slot(s), m_wo[s]);
  endtask

  task automatic rand_hooks();
    for (int s = 0; s < NWO; s++)
      m_hook[s] = {4'($urandom_range(0, 12)), 8'($urandom_range(0, 255))};
  endtask

  task automatic t_reset();
    check("R1 done low", {31'd0, done}, 32'd0);
    for (int s = 0; s < NWO; s++) check("R1 slot zero", slot(s), 32'd0);
  endtask

  task automatic t_plain_and();
    int lat;
    for (int i = 0; i < 256; i++) m_leaf[i] = '1;
    m_hook[0] = {4'd12, 8'd1};
    m_hook[1] = {4'd0, 8'd200};
    m_hook[2] = {4'd7, 8'd1};
    for (int s = 3; s < NWO; s++) m_hook[s] = {4'($urandom_range(0, 12)), 8'($urandom_range(0, 255))};
    load_leaves_hooks();  // masks left at reset value (R1)
    model_run();
    run_dut(lat, 0);
    check("R6 root word all-ones", slot(0), 32'hFFFF_FFFE);
    check("R1 R4 default AND", slot(1), 32'hFFFF_FFFF);
    compare_slots("R1 R6 plain");
    m_leaf[77] = 32'hFFFF_EFFF;
    leaf_write(8'd77, m_leaf[77]);
    for (int i = 1; i < 256; i++) leaf_write(8'(i), m_leaf[i]);
    model_run();
    run_dut(lat, 0);
    check("R6 root cleared by one leaf", {30'd0, slot(0)[1], 1'b0}, 32'd0);
    compare_slots("R6 one zero leaf");
  endtask

  task automatic t_random(int n);
    int lat;
    for (int r = 0; r < n; r++) begin
      for (int i = 0; i < 256; i++) begin
        m_leaf[i] = $urandom; m_xa[i] = $urandom; m_xb[i] = $urandom;
        m_ob[i] = $urandom & $urandom;
      end
      for (int j = 0; j < 5; j++) begin
        b_xa[j] = $urandom; b_xb[j] = $urandom; b_ob[j] = $urandom & $urandom;
      end
      rand_hooks();
      m_hook[0] = {4'd12, 8'd1};
      load_all();
      model_run();
      run_dut(lat, 0);
      compare_slots("R2 R4 R5 R6 R7 random");
    end
  endtask

  task automatic t_passthrough();
    int lat;
    for (int i = 0; i < 256; i++) begin
      m_leaf[i] = $urandom; m_xa[i] = '0; m_xb[i] = $urandom; m_ob[i] = '1;
    end
    for (int j = 0; j < 5; j++) begin b_xa[j] = '0; b_xb[j] = $urandom; b_ob[j] = '1; end
    m_hook[0] = {4'd0, 8'd133};
    m_hook[1] = {4'd1, 8'd64};
    for (int s = 2; s < NWO; s++) m_hook[s] = {4'($urandom_range(0, 12)), 8'($urandom_range(0, 255))};
    load_all();
    model_run();
    run_dut(lat, 0);
    check("R3 copy of a at level 0", slot(0), m_leaf[5]);
    check("R3 R5 copy of a at level 1", slot(1), m_leaf[0]);
    compare_slots("R3 pass-through");
  endtask

  task automatic t_invert();
    int lat;
    for (int i = 0; i < 256; i++) begin
      m_leaf[i] = $urandom; m_xa[i] = '1; m_xb[i] = '1; m_ob[i] = '0;
    end
    for (int j = 0; j < 5; j++) begin b_xa[j] = '1; b_xb[j] = '1; b_ob[j] = '0; end
    m_hook[0] = {4'd0, 8'd130};
    for (int s = 1; s < NWO; s++) m_hook[s] = {4'($urandom_range(0, 12)), 8'($urandom_range(0, 255))};
    load_all();
    model_run();
    run_dut(lat, 0);
    check("R3 R4 NOR at level 0", slot(0), ~m_leaf[2] & ~m_leaf[130]);
    compare_slots("R3 inverted");
  endtask

  task automatic t_timing();
    int lat;
    run_dut(lat, 0);
    check("R8 done latency", 32'(lat), 32'd15);
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_nocapture();
    int lat;
    logic [31:0] keep0, keep1;
    keep0 = m_wo[0]; keep1 = m_wo[1];
    for (int i = 0; i < 256; i++) m_leaf[i] = $urandom;
    m_hook[0] = {4'd15, 8'd1};
    m_hook[1] = {4'd13, 8'd200};
    load_leaves_hooks();
    model_run();
    run_dut(lat, 0);
    check("R7 level 15 keeps slot", slot(0), keep0);
    check("R7 level 13 keeps slot", slot(1), keep1);
    compare_slots("R7 mixed hooks");
  endtask

  task automatic t_busy();
    int lat, extra;
    for (int i = 0; i < 256; i++) m_leaf[i] = $urandom;
    m_hook[2] = {4'd12, 8'd200};
    m_hook[3] = {4'd12, 8'd1};
    load_leaves_hooks();
    model_run();
    run_dut(lat, 1);
    check("R8 latency with restart", 32'(lat), 32'd15);
    check("R9 leaf write ignored", slot(2), m_wo[2]);
    check("R9 cfg write ignored", slot(3), m_wo[3]);
    compare_slots("R9 busy writes");
    extra = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (done) extra++; end
    check("R8 restart ignored", 32'(extra), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_leaf[i] = '0; m_xa[i] = '0; m_xb[i] = '0; m_ob[i] = '0; end
    for (int j = 0; j < 5; j++) begin b_xa[j] = '0; b_xb[j] = '0; b_ob[j] = '0; end
    for (int s = 0; s < NWO; s++) begin m_hook[s] = 12'hF00; m_wo[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_and();
    t_timing();
    t_passthrough();
    t_invert();
    t_random(6);
    t_nocapture();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule